// File: doc/BRIEF.md
# Data Address Translation Probe

This block answers one question: what physical address does a data virtual address map to right now? It answers without side effects. It looks the address up in a set-associative translation buffer. Each way holds, for every set, a match word and a translate word:

- The match word carries a virtual page tag and a valid bit.
- The translate word carries a physical page number, four access-permission bits and a cache-inhibit bit.

The probe checks the permission that fits the current privilege level and access direction. A permission failure is reported as "no translation". It is not turned into a fault. Nothing inside the block changes because of a probe.

When translation is switched off, or no data translation unit is fitted, the block passes the address through unchanged. In that pass-through case it marks the upper half of the address space as cache-inhibited. Software loads entries through a simple write port that names a way, a set and which of the two words to write. A request strobe starts a probe. The answer appears on registered outputs one clock later and stays there until the next request.

Top module: `dtlb_probe`

## Requirements
- R1: When `mmuEnable` is 0 or `mmuPresent` is 0, a request returns `respPaddr` equal to `reqAddr`, with `respHit`=1 and `respDenied`=0.
- R2: In the pass-through case of R1, `respCacheInh` is 1 exactly when `reqAddr` is at or above 0x8000_0000, which means bit 31 is set.
- R3: The set is `reqAddr[18:13]` (page number modulo 64 sets). The compared tag is `reqAddr[31:19]`. A match word holds the tag in bits [31:19] and the valid bit in bit 0. Only an entry whose valid bit is 1 can match.
- R4: A translate word holds the physical page number in bits [31:13]. On a permitted hit, `respPaddr` is that page number followed by `reqAddr[12:0]`, and `respHit`=1.
- R5: In supervisor mode (`reqSuper`=1), a write needs translate bit 4 and a read needs translate bit 3.
- R6: In user mode (`reqSuper`=0), a write needs translate bit 2 and a read needs translate bit 1.
- R7: A hit that fails its permission check gives `respDenied`=1, `respHit`=0, `respPaddr`=0 and `respCacheInh`=0. Later probes of the same entry return the same result.
- R8: A miss gives `respPaddr`=0, `respHit`=0, `respDenied`=0 and `respCacheInh`=0.
- R9: On a permitted hit, `respCacheInh` equals bit 0 of the matching translate word.
- R10: When more than one way matches, the highest-numbered way supplies the result.
- R11: The response outputs update on the clock edge that samples `reqValid`=1. `respValid` pulses for that one cycle. Without a request, all response outputs hold their values.
- R12: Reset clears every valid bit and every response output, so each translated probe after reset misses until entries are written.
- R13: `wrSelXlate` picks the translate word (1) or the match word (0). A write becomes visible to probes from the next cycle. A probe in the same cycle as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Probe request strobe |
| reqAddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = check write permission, 0 = read permission |
| reqSuper | input | 1 | 1 = supervisor mode, 0 = user mode |
| mmuEnable | input | 1 | Translation switched on |
| mmuPresent | input | 1 | Translation unit fitted |
| wrEn | input | 1 | Entry write strobe |
| wrWay | input | 1 | Way to write |
| wrSet | input | 6 | Set to write |
| wrSelXlate | input | 1 | 1 = translate word, 0 = match word |
| wrData | input | 32 | Word to store |
| respValid | output | 1 | One-cycle pulse: response updated |
| respPaddr | output | 32 | Physical address, 0 when no translation |
| respHit | output | 1 | A translation was produced |
| respDenied | output | 1 | Entry hit but permission failed |
| respCacheInh | output | 1 | Access is cache-inhibited |

## Verification
A corrupted valid bit or tag in one way appears at the ports on the first probe that indexes that set. It appears one cycle after the request, as a spurious miss or a spurious hit. A corrupted permission or cache-inhibit bit shows up only when the probe's mode and direction select that bit. For that reason the stimulus sweeps all four mode and direction pairs against random entries. A wrong way priority is visible only when two ways hold the same tag, so that case is set up on purpose.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // Translate-word permission and attribute bit positions
  localparam int X_CACHE_INH = 0;
  localparam int X_USER_RD   = 1;
  localparam int X_USER_WR   = 2;
  localparam int X_SUPER_RD  = 3;
  localparam int X_SUPER_WR  = 4;
  localparam int X_ATTR_W    = 5;

  // Match-word valid bit position
  localparam int M_VALID = 0;

  typedef struct packed {
    logic capture;   // load response registers
    logic bypass;    // translation off or absent
    logic wrMatch;   // write match word
    logic wrXlate;   // write translate word
  } dtlbStrobes_t;

endpackage

// File: rtl/dtlb_way.sv
module dtlb_way #(
  parameter int SETS    = 64,
  parameter int TAG_W   = 13,
  parameter int PPN_W   = 19,
  parameter int ATTR_W  = 5,
  localparam int SET_W  = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrMatch,
  input  logic              wrXlate,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic              wrValid,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic [ATTR_W-1:0] wrAttr,
  input  logic [SET_W-1:0]  rdSet,
  output logic              rdValid,
  output logic [TAG_W-1:0]  rdTag,
  output logic [PPN_W-1:0]  rdPpn,
  output logic [ATTR_W-1:0] rdAttr
);

  logic [SETS-1:0]   validBits;
  logic [TAG_W-1:0]  tagMem  [SETS];
  logic [PPN_W-1:0]  ppnMem  [SETS];
  logic [ATTR_W-1:0] attrMem [SETS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (wrMatch) begin
      validBits[wrSet] <= wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (wrMatch) begin
      tagMem[wrSet] <= wrTag;
    end
    if (wrXlate) begin
      ppnMem[wrSet]  <= wrPpn;
      attrMem[wrSet] <= wrAttr;
    end
  end

  assign rdValid = validBits[rdSet];
  assign rdTag   = tagMem[rdSet];
  assign rdPpn   = ppnMem[rdSet];
  assign rdAttr  = attrMem[rdSet];

endmodule

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         mmuEnable,
  input  logic         mmuPresent,
  input  logic         wrEn,
  input  logic         wrSelXlate,
  output dtlbStrobes_t strobes,
  output logic         respValid
);

  always_comb begin
    strobes.capture = reqValid;
    strobes.bypass  = !(mmuEnable && mmuPresent);
    strobes.wrMatch = wrEn && !wrSelXlate;
    strobes.wrXlate = wrEn && wrSelXlate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

endmodule

// File: rtl/dtlb_datapath.sv
module dtlb_datapath
  import dtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SETS      = 64,
  parameter int WAYS      = 2,
  localparam int SET_W    = $clog2(SETS),
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W    = ADDR_W - PAGE_BITS - SET_W,
  localparam int PPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtlbStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSuper,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [SET_W-1:0]  wrSet,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] respPaddr,
  output logic              respHit,
  output logic              respDenied,
  output logic              respCacheInh
);

  logic [SET_W-1:0]    lookSet;
  logic [TAG_W-1:0]    lookTag;
  logic [PAGE_BITS-1:0] lookOffset;

  assign lookOffset = reqAddr[PAGE_BITS-1:0];
  assign lookSet    = reqAddr[PAGE_BITS +: SET_W];
  assign lookTag    = reqAddr[ADDR_W-1 -: TAG_W];

  logic                wayValid [WAYS];
  logic [TAG_W-1:0]    wayTag   [WAYS];
  logic [PPN_W-1:0]    wayPpn   [WAYS];
  logic [X_ATTR_W-1:0] wayAttr  [WAYS];

  // Bits of the write word that neither word layout uses
  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[PAGE_BITS-1:X_ATTR_W], wrData[PAGE_BITS+SET_W-1:1]};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic selThis;
    assign selThis = (wrWay == WAY_W'(w));

    dtlb_way #(
      .SETS   (SETS),
      .TAG_W  (TAG_W),
      .PPN_W  (PPN_W),
      .ATTR_W (X_ATTR_W)
    ) u_way (
      .clk     (clk),
      .rstN    (rstN),
      .wrMatch (strobes.wrMatch && selThis),
      .wrXlate (strobes.wrXlate && selThis),
      .wrSet   (wrSet),
      .wrTag   (wrData[ADDR_W-1 -: TAG_W]),
      .wrValid (wrData[M_VALID]),
      .wrPpn   (wrData[ADDR_W-1 -: PPN_W]),
      .wrAttr  (wrData[X_ATTR_W-1:0]),
      .rdSet   (lookSet),
      .rdValid (wayValid[w]),
      .rdTag   (wayTag[w]),
      .rdPpn   (wayPpn[w]),
      .rdAttr  (wayAttr[w])
    );
  end

  // Way select: later (higher) ways override earlier ones
  logic                anyMatch;
  logic [PPN_W-1:0]    selPpn;
  logic [X_ATTR_W-1:0] selAttr;

  always_comb begin
    anyMatch = 1'b0;
    selPpn   = '0;
    selAttr  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (wayValid[w] && (wayTag[w] == lookTag)) begin
        anyMatch = 1'b1;
        selPpn   = wayPpn[w];
        selAttr  = wayAttr[w];
      end
    end
  end

  logic permitted;
  always_comb begin
    if (reqSuper) permitted = reqWrite ? selAttr[X_SUPER_WR] : selAttr[X_SUPER_RD];
    else          permitted = reqWrite ? selAttr[X_USER_WR]  : selAttr[X_USER_RD];
  end

  logic [ADDR_W-1:0] nextPaddr;
  logic              nextHit, nextDenied, nextCacheInh;

  always_comb begin
    nextPaddr    = '0;
    nextHit      = 1'b0;
    nextDenied   = 1'b0;
    nextCacheInh = 1'b0;
    if (strobes.bypass) begin
      nextPaddr    = reqAddr;
      nextHit      = 1'b1;
      nextCacheInh = reqAddr[ADDR_W-1];
    end else if (anyMatch && permitted) begin
      nextPaddr    = {selPpn, lookOffset};
      nextHit      = 1'b1;
      nextCacheInh = selAttr[X_CACHE_INH];
    end else if (anyMatch) begin
      nextDenied   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respPaddr    <= '0;
      respHit      <= 1'b0;
      respDenied   <= 1'b0;
      respCacheInh <= 1'b0;
    end else if (strobes.capture) begin
      respPaddr    <= nextPaddr;
      respHit      <= nextHit;
      respDenied   <= nextDenied;
      respCacheInh <= nextCacheInh;
    end
  end

endmodule

// File: rtl/dtlb_probe.sv
module dtlb_probe
  import dtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SETS      = 64,
  parameter int WAYS      = 2,
  localparam int SET_W    = $clog2(SETS),
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSuper,
  input  logic              mmuEnable,
  input  logic              mmuPresent,
  input  logic              wrEn,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [SET_W-1:0]  wrSet,
  input  logic              wrSelXlate,
  input  logic [ADDR_W-1:0] wrData,
  output logic              respValid,
  output logic [ADDR_W-1:0] respPaddr,
  output logic              respHit,
  output logic              respDenied,
  output logic              respCacheInh
);

  dtlbStrobes_t strobes;

  dtlb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .mmuEnable  (mmuEnable),
    .mmuPresent (mmuPresent),
    .wrEn       (wrEn),
    .wrSelXlate (wrSelXlate),
    .strobes    (strobes),
    .respValid  (respValid)
  );

  dtlb_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .SETS      (SETS),
    .WAYS      (WAYS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqSuper     (reqSuper),
    .wrWay        (wrWay),
    .wrSet        (wrSet),
    .wrData       (wrData),
    .respPaddr    (respPaddr),
    .respHit      (respHit),
    .respDenied   (respDenied),
    .respCacheInh (respCacheInh)
  );

endmodule

// File: rtl/dtlb_probe_checker.sv
module dtlb_probe_checker #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              mmuEnable,
  input logic              mmuPresent,
  input logic              respValid,
  input logic [ADDR_W-1:0] respPaddr,
  input logic              respHit,
  input logic              respDenied,
  input logic              respCacheInh
);

  // R1: pass-through returns the address unchanged
  a_r1_bypass_identity: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !(mmuEnable && mmuPresent) |=>
      (respPaddr == $past(reqAddr)) && respHit && !respDenied);

  // R2: pass-through cache-inhibit follows the top address bit
  a_r2_bypass_ci: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !(mmuEnable && mmuPresent) |=>
      respCacheInh == $past(reqAddr[ADDR_W-1]));

  // R4: a translated hit keeps the page offset
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !respHit || (respPaddr[PAGE_BITS-1:0] == $past(reqAddr[PAGE_BITS-1:0])));

  // R7: a denied probe yields no translation
  a_r7_denied_empty: assert property (@(posedge clk) disable iff (!rstN)
    respDenied |-> (respPaddr == '0) && !respHit && !respCacheInh);

  // R8: no hit means zero address and no cache-inhibit
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> (respPaddr == '0) && !respCacheInh);

  // R11: response valid pulse follows request by one cycle
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  a_r11_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  // R11: outputs hold without a request
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(respPaddr) && $stable(respHit) &&
                  $stable(respDenied) && $stable(respCacheInh));

  // R7/R8: hit and denied never together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({respHit, respDenied}) <= 1);

endmodule

bind dtlb_probe dtlb_probe_checker #(
  .ADDR_W    (ADDR_W),
  .PAGE_BITS (PAGE_BITS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqAddr      (reqAddr),
  .mmuEnable    (mmuEnable),
  .mmuPresent   (mmuPresent),
  .respValid    (respValid),
  .respPaddr    (respPaddr),
  .respHit      (respHit),
  .respDenied   (respDenied),
  .respCacheInh (respCacheInh)
);

// File: tb/tb_dtlb_probe.sv
module tb_dtlb_probe;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqSuper = 1'b0;
  logic        mmuEnable = 1'b1;
  logic        mmuPresent = 1'b1;
  logic        wrEn = 1'b0;
  logic        wrWay = 1'b0;
  logic [5:0]  wrSet = '0;
  logic        wrSelXlate = 1'b0;
  logic [31:0] wrData = '0;
  logic        respValid;
  logic [31:0] respPaddr;
  logic        respHit, respDenied, respCacheInh;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dtlb_probe dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .mmuEnable(mmuEnable),
    .mmuPresent(mmuPresent), .wrEn(wrEn), .wrWay(wrWay), .wrSet(wrSet),
    .wrSelXlate(wrSelXlate), .wrData(wrData), .respValid(respValid),
    .respPaddr(respPaddr), .respHit(respHit), .respDenied(respDenied),
    .respCacheInh(respCacheInh)
  );

  // Reference contents
  logic [12:0] mTag   [2][64];
  logic        mValid [2][64];
  logic [18:0] mPpn   [2][64];
  logic [4:0]  mAttr  [2][64];

  // Expected {paddr, hit, denied, ci}
  function automatic logic [34:0] model(logic [31:0] a, logic wr, logic sup,
                                        logic en, logic pres);
    logic [5:0] s;
    logic found;
    logic [18:0] p;
    logic [4:0] at;
    logic ok;
    if (!(en && pres)) return {a, 1'b1, 1'b0, a[31]};
    s = a[18:13];
    found = 0; p = '0; at = '0;
    for (int w = 0; w < 2; w++)
      if (mValid[w][s] && mTag[w][s] == a[31:19]) begin
        found = 1; p = mPpn[w][s]; at = mAttr[w][s];
      end
    if (!found) return 35'd0;
    ok = sup ? (wr ? at[4] : at[3]) : (wr ? at[2] : at[1]);
    if (!ok) return {32'd0, 1'b0, 1'b1, 1'b0};
    return {p, a[12:0], 1'b1, 1'b0, at[0]};
  endfunction

  task automatic check(string req, logic [34:0] exp);
    logic [34:0] act;
    act = {respPaddr, respHit, respDenied, respCacheInh};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual paddr=%h hit=%b den=%b ci=%b expected paddr=%h hit=%b den=%b ci=%b",
               req, act[34:3], act[2], act[1], act[0], exp[34:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic writeMatch(logic w, logic [5:0] s, logic [12:0] tag, logic v);
    @(negedge clk);
    wrEn = 1; wrWay = w; wrSet = s; wrSelXlate = 0; wrData = {tag, 18'd0, v};
    @(negedge clk);
    wrEn = 0;
    mTag[w][s] = tag; mValid[w][s] = v;
  endtask

  task automatic writeXlate(logic w, logic [5:0] s, logic [18:0] ppn, logic [4:0] at);
    @(negedge clk);
    wrEn = 1; wrWay = w; wrSet = s; wrSelXlate = 1; wrData = {ppn, 8'd0, at};
    @(negedge clk);
    wrEn = 0;
    mPpn[w][s] = ppn; mAttr[w][s] = at;
  endtask

  // Issue one probe; returns with outputs settled and sampled at a negedge
  task automatic probe(logic [31:0] a, logic wr, logic sup, logic en, logic pres);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqWrite = wr; reqSuper = sup;
    mmuEnable = en; mmuPresent = pres;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic probeCheck(string req, logic [31:0] a, logic wr, logic sup,
                            logic en, logic pres);
    probe(a, wr, sup, en, pres);
    check(req, model(a, wr, sup, en, pres));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 64; s++) begin
        mTag[w][s] = '0; mValid[w][s] = 0; mPpn[w][s] = '0; mAttr[w][s] = '0;
      end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R12: reset state
    check("R12 reset outputs", 35'd0);
    checkBit("R11 respValid idle after reset", respValid, 1'b0);
    writeXlate(0, 6'd5, 19'h1234, 5'b11111);
    writeXlate(1, 6'd5, 19'h0abc, 5'b11111);
    probeCheck("R12 miss after reset", {13'h0, 6'd5, 13'h10}, 0, 1, 1, 1);
    checkBit("R12 hit low", respHit, 1'b0);

    // R1, R2: pass-through
    probeCheck("R1 disabled", 32'h1234_5678, 0, 0, 0, 1);
    probeCheck("R1 absent", 32'h0bad_cafe, 1, 1, 1, 0);
    probeCheck("R2 at 0x80000000", 32'h8000_0000, 0, 0, 0, 0);
    checkBit("R2 ci high", respCacheInh, 1'b1);
    probeCheck("R2 below 0x80000000", 32'h7fff_ffff, 0, 0, 0, 1);
    checkBit("R2 ci low", respCacheInh, 1'b0);

    // R3, R4: basic hit and invalid entry
    writeMatch(0, 6'd5, 13'h0aa, 1);
    probeCheck("R4 hit", {13'h0aa, 6'd5, 13'h1f0}, 0, 0, 1, 1);
    checkBit("R4 hit flag", respHit, 1'b1);
    probeCheck("R3 wrong set", {13'h0aa, 6'd6, 13'h1f0}, 0, 0, 1, 1);
    writeMatch(0, 6'd5, 13'h0aa, 0);
    probeCheck("R3 invalid entry", {13'h0aa, 6'd5, 13'h1f0}, 0, 0, 1, 1);
    checkBit("R3 no hit", respHit, 1'b0);

    // R5, R6, R7, R9: permissions and cache-inhibit
    writeMatch(1, 6'd9, 13'h111, 1);
    for (int a = 0; a < 32; a++) begin
      writeXlate(1, 6'd9, 19'h7_0000 | 19'(a), 5'(a));
      for (int m = 0; m < 4; m++) begin
        probeCheck(m[1] ? "R5 supervisor perm" : "R6 user perm",
                   {13'h111, 6'd9, 13'h0a5}, m[0], m[1], 1, 1);
      end
    end
    writeXlate(1, 6'd9, 19'h4_4444, 5'b00001);
    probeCheck("R7 denied", {13'h111, 6'd9, 13'h0}, 0, 1, 1, 1);
    checkBit("R7 denied flag", respDenied, 1'b1);
    probeCheck("R7 no state change", {13'h111, 6'd9, 13'h0}, 0, 1, 1, 1);
    writeXlate(1, 6'd9, 19'h4_4444, 5'b01001);
    probeCheck("R9 ci from entry", {13'h111, 6'd9, 13'h3}, 0, 1, 1, 1);
    checkBit("R9 ci set", respCacheInh, 1'b1);

    // R10: both ways match
    writeMatch(0, 6'd20, 13'h0f0, 1);
    writeMatch(1, 6'd20, 13'h0f0, 1);
    writeXlate(0, 6'd20, 19'h1_1111, 5'b11110);
    writeXlate(1, 6'd20, 19'h2_2222, 5'b11111);
    probeCheck("R10 highest way", {13'h0f0, 6'd20, 13'h77}, 0, 0, 1, 1);
    checkBit("R10 ci from way 1", respCacheInh, 1'b1);

    // R11: hold without request
    repeat (3) @(negedge clk);
    check("R11 hold", model({13'h0f0, 6'd20, 13'h77}, 0, 0, 1, 1));
    checkBit("R11 respValid low", respValid, 1'b0);

    // R13: same-cycle write and probe sees old contents
    @(negedge clk);
    wrEn = 1; wrWay = 0; wrSet = 6'd33; wrSelXlate = 0; wrData = {13'h1aa, 18'd0, 1'b1};
    writeXlate(0, 6'd33, 19'h3_3333, 5'b11111);
    // wrData above was overwritten by the task; set up again cleanly
    writeMatch(0, 6'd33, 13'h000, 0);
    @(negedge clk);
    wrEn = 1; wrWay = 0; wrSet = 6'd33; wrSelXlate = 0; wrData = {13'h1aa, 18'd0, 1'b1};
    reqValid = 1; reqAddr = {13'h1aa, 6'd33, 13'h5}; reqWrite = 0; reqSuper = 1;
    mmuEnable = 1; mmuPresent = 1;
    @(negedge clk);
    wrEn = 0; reqValid = 0;
    check("R13 same-cycle old contents", 35'd0);
    mTag[0][33] = 13'h1aa; mValid[0][33] = 1;
    probeCheck("R13 visible next cycle", {13'h1aa, 6'd33, 13'h5}, 0, 1, 1, 1);
    checkBit("R13 hit", respHit, 1'b1);
    // translate-word select leaves match word intact
    writeXlate(0, 6'd33, 19'h5_5555, 5'b11111);
    probeCheck("R13 xlate select", {13'h1aa, 6'd33, 13'h5}, 0, 1, 1, 1);

    // Random fill and random probes
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 64; s++) begin
        writeMatch(w[0], 6'(s), 13'($urandom), 1'($urandom_range(0, 3) != 0));
        writeXlate(w[0], 6'(s), 19'($urandom), 5'($urandom));
      end
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic wr, sup, en, pres;
      logic [34:0] e;
      int ww;
      logic [5:0] ss;
      string tag;
      if ($urandom_range(0, 19) == 0) begin
        writeXlate(1'($urandom), 6'($urandom), 19'($urandom), 5'($urandom));
      end
      ss = 6'($urandom);
      ww = $urandom_range(0, 1);
      a = $urandom;
      if ($urandom_range(0, 3) != 0) a = {mTag[ww][ss], ss, a[12:0]};
      wr = 1'($urandom); sup = 1'($urandom);
      en = ($urandom_range(0, 9) != 0); pres = ($urandom_range(0, 9) != 0);
      e = model(a, wr, sup, en, pres);
      if (!(en && pres)) tag = "R1 random bypass";
      else if (e[1]) tag = "R7 random denied";
      else if (e[2]) tag = sup ? "R5 random hit" : "R6 random hit";
      else tag = "R8 random miss";
      probe(a, wr, sup, en, pres);
      check(tag, e);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule